// File: doc/BRIEF.md
# Pipelined Cartesian-to-Polar Converter

This block turns a signed two-component vector (x, y) into its length and its direction angle. It uses circular vectoring by shift-and-add micro-rotations: each rotation steers the vector toward the positive x axis. The rotation loop is laid out in space, one hard-wired iteration per register stage. A fresh sample can therefore enter on every clock, and each result leaves a fixed number of cycles later.

An input fold stage mirrors left half-plane vectors through the origin, so the rotation chain only sees angles it can resolve. It keeps a note of the half-turn it removed. A closing stage takes the rotation gain out of the length with a fixed shift-and-add network, rounds both results and adds the half-turn back to the angle. Upstream logic presents a sample with a valid strobe, and downstream logic takes the result when the output strobe is high. There is no back-pressure.

Top module: `rect2polar_pipe`

## Requirements
- R1: While reset is asserted, and until the first valid sample has crossed the pipeline, out_valid stays low.
- R2: A sample taken with in_valid high appears with out_valid high exactly ITER+2 clock cycles later (18 cycles with defaults).
- R3: Samples presented on consecutive cycles come out on consecutive cycles, in the same order.
- R4: out_mag is the unsigned length sqrt(x*x+y*y), within 6 LSB.
- R5: out_ang is a 16-bit two's-complement angle in which 2^15 counts stand for pi radians. It lies within 4 LSB, taken modulo 2^16, of atan2(y, x).
- R6: Vectors with negative x, in both the second and the third quadrant, get angles with the correct sign and magnitude beyond plus or minus pi/2.
- R7: A vector on the negative x axis (y = 0, x < 0) yields an angle within 4 LSB, modulo 2^16, of -32768. The angle range wraps into [-pi, pi).
- R8: The input x = 0, y = 0 yields exactly out_mag = 0 and out_ang = 0.
- R9: The extreme input x = -32768, y = -32768 gives length 46341 within 6 LSB and angle -24576 within 4 LSB, with no internal overflow.
- R10: A cycle with in_valid low produces a cycle with out_valid low, ITER+2 cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Qualifies in_x and in_y for this cycle |
| in_x | input | 16 | Signed x component |
| in_y | input | 16 | Signed y component |
| out_valid | output | 1 | Qualifies out_mag and out_ang |
| out_mag | output | 16 | Unsigned vector length |
| out_ang | output | 16 | Signed angle, 2^15 counts = pi |

## Verification
Two actions can meet on one sample in the same cycle: the half-turn correction restored at the output, and the wrap of the angle at plus or minus pi. This happens on the negative x axis and on left half-plane vectors just above or below it. The stimulus places such vectors in a back-to-back burst and also between bubbles. Each result is judged against a real-valued atan2 and square root, with the angle difference taken modulo 2^16 so that a result on either side of the wrap is accepted. The zero vector also runs back to back with non-zero vectors, to show that forcing it to zero does not disturb its neighbours.

// File: rtl/rp_pkg.sv
package rp_pkg;

  // Half-turn removed by the input fold, restored at the output
  typedef enum logic [1:0] {
    FOLD_NONE   = 2'd0,
    FOLD_ADD_PI = 2'd1,
    FOLD_SUB_PI = 2'd2
  } fold_e;

  // Elementary angle atan(2^-idx) in counts where 2^scale_log2 counts = pi
  function automatic int atan_count(input int idx, input int scale_log2);
    real t;
    real acc;
    real pw;
    real sc;
    t  = 1.0;
    for (int k = 0; k < idx; k++) t = t / 2.0;
    sc = 1.0;
    for (int k = 0; k < scale_log2; k++) sc = sc * 2.0;
    if (idx == 0) begin
      acc = 0.78539816339744831;
    end else begin
      acc = 0.0;
      pw  = t;
      for (int k = 0; k < 40; k++) begin
        if (k % 2 == 1) acc = acc - pw / real'(2 * k + 1);
        else            acc = acc + pw / real'(2 * k + 1);
        pw = pw * t * t;
      end
    end
    return int'(acc / 3.14159265358979324 * sc);
  endfunction

endpackage

// File: rtl/rp_prefold.sv
module rp_prefold
  import rp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FRAC   = 3,
  parameter int XW     = 21
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_x,
  input  logic signed [DATA_W-1:0] in_y,
  output logic                     out_valid,
  output logic signed [XW-1:0]     out_x,
  output logic signed [XW-1:0]     out_y,
  output fold_e                    out_fold,
  output logic                     out_zero
);

  localparam int EXT = XW - DATA_W - FRAC;

  logic signed [XW-1:0] xe, ye, x_d, y_d;
  fold_e                fold_d;
  logic                 zero_d;

  always_comb begin
    xe     = {{EXT{in_x[DATA_W-1]}}, in_x, {FRAC{1'b0}}};
    ye     = {{EXT{in_y[DATA_W-1]}}, in_y, {FRAC{1'b0}}};
    zero_d = (in_x == '0) && (in_y == '0);
    if (in_x[DATA_W-1]) begin
      x_d    = -xe;
      y_d    = -ye;
      fold_d = in_y[DATA_W-1] ? FOLD_SUB_PI : FOLD_ADD_PI;
    end else begin
      x_d    = xe;
      y_d    = ye;
      fold_d = FOLD_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_x     <= '0;
      out_y     <= '0;
      out_fold  <= FOLD_NONE;
      out_zero  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_x    <= x_d;
        out_y    <= y_d;
        out_fold <= fold_d;
        out_zero <= zero_d;
      end
    end
  end

  // R6: after folding, the vector sits in the right half-plane
  a_r6_folded_right: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_x[XW-1]);

  // R6: a half-turn is recorded exactly when the input x was negative
  a_r6_fold_recorded: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((out_fold != FOLD_NONE) == $past(in_x[DATA_W-1])));

endmodule

// File: rtl/rp_stage.sv
module rp_stage
  import rp_pkg::*;
#(
  parameter int XW    = 21,
  parameter int ZW    = 19,
  parameter int IDX   = 0,
  parameter int ZLOG2 = 18
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [XW-1:0] in_x,
  input  logic signed [XW-1:0] in_y,
  input  logic signed [ZW-1:0] in_z,
  input  fold_e                in_fold,
  input  logic                 in_zero,
  output logic                 out_valid,
  output logic signed [XW-1:0] out_x,
  output logic signed [XW-1:0] out_y,
  output logic signed [ZW-1:0] out_z,
  output fold_e                out_fold,
  output logic                 out_zero
);

  // Elementary angle for this iteration, fixed per stage
  localparam logic signed [ZW-1:0] STEP = ZW'(atan_count(IDX, ZLOG2));

  logic signed [XW-1:0] xs, ys, x_d, y_d;
  logic signed [ZW-1:0] z_d;

  always_comb begin
    xs = in_x >>> IDX;
    ys = in_y >>> IDX;
    if (!in_y[XW-1]) begin
      x_d = in_x + ys;
      y_d = in_y - xs;
      z_d = in_z + STEP;
    end else begin
      x_d = in_x - ys;
      y_d = in_y + xs;
      z_d = in_z - STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_x     <= '0;
      out_y     <= '0;
      out_z     <= '0;
      out_fold  <= FOLD_NONE;
      out_zero  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_x    <= x_d;
        out_y    <= y_d;
        out_z    <= z_d;
        out_fold <= in_fold;
        out_zero <= in_zero;
      end
    end
  end

  // R2: a valid sample advances exactly one stage per clock
  a_r2_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R10: a bubble stays a bubble
  a_r10_bubble_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R4: x never decreases while vectoring from the right half-plane
  a_r4_x_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_x[XW-1]) |=> (out_x >= $past(in_x)));

endmodule

// File: rtl/rp_finish.sv
module rp_finish
  import rp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ANG_W  = 16,
  parameter int FRAC   = 3,
  parameter int ZF     = 3,
  parameter int XW     = 21,
  parameter int ZW     = 19
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [XW-1:0]    in_x,
  input  logic signed [ZW-1:0]    in_z,
  input  fold_e                   in_fold,
  input  logic                    in_zero,
  output logic                    out_valid,
  output logic [DATA_W-1:0]       out_mag,
  output logic signed [ANG_W-1:0] out_ang
);

  localparam logic signed [XW-1:0]    MAG_HALF = XW'(1) <<< (FRAC - 1);
  localparam logic signed [ZW-1:0]    Z_HALF   = ZW'(1) <<< (ZF - 1);
  localparam logic signed [ANG_W-1:0] HALF_TURN = {1'b1, {(ANG_W-1){1'b0}}};

  logic signed [XW-1:0]    scaled;
  logic [DATA_W-1:0]       mag_d;
  logic signed [ANG_W-1:0] ang_base, ang_d;

  always_comb begin
    // Gain removal: 1/1.6468 ~ 2^-1 + 2^-3 - 2^-6 - 2^-9 - 2^-13 - 2^-15
    scaled   = (in_x >>> 1) + (in_x >>> 3) - (in_x >>> 6)
             - (in_x >>> 9) - (in_x >>> 13) - (in_x >>> 15);
    mag_d    = DATA_W'((scaled + MAG_HALF) >>> FRAC);
    ang_base = ANG_W'((in_z + Z_HALF) >>> ZF);
    unique case (in_fold)
      FOLD_ADD_PI: ang_d = ang_base + HALF_TURN;
      FOLD_SUB_PI: ang_d = ang_base - HALF_TURN;
      default:     ang_d = ang_base;
    endcase
    if (in_zero) begin
      mag_d = '0;
      ang_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_mag   <= '0;
      out_ang   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_mag <= mag_d;
        out_ang <= ang_d;
      end
    end
  end

  // R8: a zero vector leaves as exact zeros
  a_r8_zero_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_zero) |=> (out_mag == '0 && out_ang == '0));

  // R2: the output strobe follows the last stage by one clock
  a_r2_out_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

endmodule

// File: rtl/rect2polar_pipe.sv
module rect2polar_pipe
  import rp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ANG_W  = 16,
  parameter int GUARD  = 2,
  parameter int FRAC   = 3,
  parameter int ZF     = 3,
  parameter int ITER   = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_x,
  input  logic signed [DATA_W-1:0] in_y,
  output logic                     out_valid,
  output logic [DATA_W-1:0]        out_mag,
  output logic signed [ANG_W-1:0]  out_ang
);

  localparam int XW      = DATA_W + GUARD + FRAC;
  localparam int ZW      = ANG_W + ZF;
  localparam int ZLOG2   = ANG_W - 1 + ZF;
  localparam int Y_BOUND = 1 << (XW - ITER + 3);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_n_core;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_core = rst_sync[1];

  logic                 sv [0:ITER];
  logic signed [XW-1:0] sx [0:ITER];
  logic signed [XW-1:0] sy [0:ITER];
  logic signed [ZW-1:0] sz [0:ITER];
  fold_e                sf [0:ITER];
  logic                 s0 [0:ITER];

  rp_prefold #(.DATA_W(DATA_W), .FRAC(FRAC), .XW(XW)) u_fold (
    .clk(clk), .rst_n(rst_n_core), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
    .out_valid(sv[0]), .out_x(sx[0]), .out_y(sy[0]), .out_fold(sf[0]), .out_zero(s0[0])
  );
  assign sz[0] = '0;

  for (genvar k = 0; k < ITER; k++) begin : g_iter
    rp_stage #(.XW(XW), .ZW(ZW), .IDX(k), .ZLOG2(ZLOG2)) u_stage (
      .clk(clk), .rst_n(rst_n_core),
      .in_valid(sv[k]), .in_x(sx[k]), .in_y(sy[k]), .in_z(sz[k]),
      .in_fold(sf[k]), .in_zero(s0[k]),
      .out_valid(sv[k+1]), .out_x(sx[k+1]), .out_y(sy[k+1]), .out_z(sz[k+1]),
      .out_fold(sf[k+1]), .out_zero(s0[k+1])
    );
  end

  rp_finish #(.DATA_W(DATA_W), .ANG_W(ANG_W), .FRAC(FRAC), .ZF(ZF), .XW(XW), .ZW(ZW)) u_finish (
    .clk(clk), .rst_n(rst_n_core),
    .in_valid(sv[ITER]), .in_x(sx[ITER]), .in_z(sz[ITER]),
    .in_fold(sf[ITER]), .in_zero(s0[ITER]),
    .out_valid(out_valid), .out_mag(out_mag), .out_ang(out_ang)
  );

  // R4: the residual y component has been driven close to zero at the end of the chain
  a_r4_y_converged: assert property (@(posedge clk) disable iff (!rst_n_core)
    sv[ITER] |-> (sy[ITER] < XW'(Y_BOUND) && sy[ITER] > -XW'(Y_BOUND)));

  // R1: no output strobe while the core is held in reset
  a_r1_quiet_reset: assert property (@(posedge clk)
    !rst_n_core |-> !out_valid);

endmodule

// File: tb/rect2polar_pipe_tb.sv
module rect2polar_pipe_tb;

  localparam int LAT     = 18;
  localparam int MAG_TOL = 6;
  localparam int ANG_TOL = 4;
  localparam int NSLOT   = 220;
  localparam real PI     = 3.14159265358979324;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic signed [15:0] in_x = '0;
  logic signed [15:0] in_y = '0;
  logic               out_valid;
  logic [15:0]        out_mag;
  logic signed [15:0] out_ang;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  int slot_v [0:NSLOT-1];
  int slot_x [0:NSLOT-1];
  int slot_y [0:NSLOT-1];
  int hv [0:1023];
  int hx [0:1023];
  int hy [0:1023];

  always #10 clk = ~clk;

  rect2polar_pipe u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
    .out_valid(out_valid), .out_mag(out_mag), .out_ang(out_ang)
  );

  function automatic string tag_for(input int x, input int y);
    if (x == 0 && y == 0)           return "R8";
    if (x == -32768 && y == -32768) return "R9";
    if (x < 0 && y == 0)            return "R7";
    if (x < 0)                      return "R6";
    return "R4/R5";
  endfunction

  task automatic check_result(input int x, input int y);
    real    mr, ar;
    int     em, ea, d;
    string  t;
    t = tag_for(x, y);
    if (x == 0 && y == 0) begin
      tests++;
      if (out_mag != 0 || out_ang != 0) begin
        fails++;
        $display("FAIL R8 zero vector: mag=%0d ang=%0d expected 0 0", out_mag, out_ang);
      end
      return;
    end
    mr = $sqrt(real'(x) * real'(x) + real'(y) * real'(y));
    em = int'(mr);
    ar = $atan2(real'(y), real'(x)) / PI * 32768.0;
    ea = int'(ar);
    tests++;
    d = int'(out_mag) - em;
    if (d > MAG_TOL || d < -MAG_TOL) begin
      fails++;
      $display("FAIL %s R4 magnitude (%0d,%0d): got %0d expected %0d", t, x, y, out_mag, em);
    end
    tests++;
    d = int'(out_ang) - ea;
    while (d > 32767)  d -= 65536;
    while (d < -32768) d += 65536;
    if (d > ANG_TOL || d < -ANG_TOL) begin
      fails++;
      $display("FAIL %s R5 angle (%0d,%0d): got %0d expected %0d", t, x, y, out_ang, ea);
    end
  endtask

  initial begin : stim
    int n;
    real a;
    n = 0;
    for (int k = 0; k < NSLOT; k++) begin
      slot_v[k] = 0; slot_x[k] = 0; slot_y[k] = 0;
    end
    // directed cases, back to back
    slot_v[n] = 1; slot_x[n] = 0;      slot_y[n] = 0;      n++;
    slot_v[n] = 1; slot_x[n] = 20000;  slot_y[n] = 0;      n++;
    slot_v[n] = 1; slot_x[n] = 0;      slot_y[n] = 20000;  n++;
    slot_v[n] = 1; slot_x[n] = -20000; slot_y[n] = 0;      n++;
    slot_v[n] = 1; slot_x[n] = 0;      slot_y[n] = 0;      n++;
    slot_v[n] = 1; slot_x[n] = 0;      slot_y[n] = -20000; n++;
    slot_v[n] = 1; slot_x[n] = -32768; slot_y[n] = -32768; n++;
    slot_v[n] = 1; slot_x[n] = 32767;  slot_y[n] = 32767;  n++;
    slot_v[n] = 1; slot_x[n] = -15000; slot_y[n] = 12000;  n++;
    slot_v[n] = 1; slot_x[n] = -9000;  slot_y[n] = -21000; n++;
    slot_v[n] = 1; slot_x[n] = -500;   slot_y[n] = 0;      n++;
    slot_v[n] = 1; slot_x[n] = -30000; slot_y[n] = 40;     n++;
    slot_v[n] = 1; slot_x[n] = -30000; slot_y[n] = -40;    n++;
    slot_v[n] = 1; slot_x[n] = 1000;   slot_y[n] = -3000;  n++;
    slot_v[n] = 1; slot_x[n] = 32767;  slot_y[n] = -32768; n++;
    n++;                                                    // R10 bubble
    // R3: back-to-back sweep around the circle
    for (int k = 0; k < 64; k++) begin
      a = 2.0 * PI * real'(k) / 64.0;
      slot_v[n] = 1;
      slot_x[n] = int'((3000.0 + 400.0 * real'(k)) * $cos(a));
      slot_y[n] = int'((3000.0 + 400.0 * real'(k)) * $sin(a));
      n++;
    end
    // R10: sweep with every third slot left empty
    for (int k = 0; k < 60; k++) begin
      a = 2.0 * PI * real'(k) / 60.0 + 0.05;
      if (k % 3 != 2) begin
        slot_v[n] = 1;
        slot_x[n] = int'(25000.0 * $cos(a));
        slot_y[n] = int'(25000.0 * $sin(a));
      end
      n++;
    end
  end

  initial begin : main
    int c;
    int ev;
    // R1: reset state
    repeat (5) begin
      @(negedge clk);
      tests++;
      if (out_valid !== 1'b0) begin
        fails++;
        $display("FAIL R1 out_valid during reset: got %b expected 0", out_valid);
      end
    end
    rst_n = 1'b1;
    for (c = 0; c < NSLOT + LAT + 10; c++) begin
      @(negedge clk);
      // outputs for the sample driven LAT cycles earlier
      ev = (c >= LAT) ? hv[c - LAT] : 0;
      tests++;
      if (out_valid !== ev[0]) begin
        fails++;
        $display("FAIL %s out_valid at step %0d: got %b expected %0d",
                 (ev != 0) ? "R2/R3" : ((c >= LAT) ? "R10" : "R1"), c, out_valid, ev);
      end else if (ev != 0) begin
        check_result(hx[c - LAT], hy[c - LAT]);
      end
      // drive next sample (four idle steps first while the reset release settles)
      if (c >= 4 && c - 4 < NSLOT) begin
        hv[c] = slot_v[c - 4];
        hx[c] = slot_x[c - 4];
        hy[c] = slot_y[c - 4];
      end else begin
        hv[c] = 0; hx[c] = 0; hy[c] = 0;
      end
      in_valid = hv[c][0];
      in_x     = 16'(hx[c]);
      in_y     = 16'(hy[c]);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule